// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Stalling Transmit

This block is a byte-wide asynchronous serial port that sits as a slave on a simple word-addressed CPU memory bus. Software sets the bit period with a divider register, turns the port on with an enable register, and moves bytes through a single data register. A write to the data register starts a frame on the transmit line at once. The block has no transmit buffer. A second data write that arrives while a frame is still going out is held off with bus wait states until the line is free. The stalled write then completes and its byte is sent.

Received frames are checked and placed in a one-byte holding register. A read of the data register returns that byte and empties the register. A read that finds the register empty returns all ones, so software tests for 0xFFFFFFFF instead of polling a status flag. A newer byte replaces an unread one. Frames are 8N1: a low start bit, eight data bits with the least significant bit first, and one high stop bit. The transmit line idles high.

Top module: `mmio_uart`

## Requirements
- R1: After reset the divider reads 1, the enable register reads 0, the data register reads 0xFFFFFFFF and `line_tx` is high.
- R2: The word at byte offset 0x0 is the 32-bit divider. It can be read and written. Each serial bit lasts that many clock cycles, and a value of 0 acts as 1.
- R3: The word at byte offset 0x8 keeps the low 8 bits of a write and reads them back with the upper 24 bits at zero. The port runs only while this field is nonzero.
- R4: With the port enabled and the transmitter idle, a write to the data word at offset 0x4 completes in the cycle it is presented. `line_tx` goes low in the next cycle. The frame is start 0, the eight bits of `bus_wdata[7:0]` with the least significant bit first, and stop 1, each bit lasting one divider period.
- R5: A data write presented while a frame is in flight sees `bus_ready` low for every cycle until the frame ends (10 bit periods after the first write was accepted). It is then accepted, and its byte is sent as the next frame.
- R6: A frame received on `line_rx` with a high stop bit stores its byte in the holding register. `line_rx` passes through a two-stage synchronizer. The start bit is confirmed half a period after the falling edge, and each data bit is sampled at the middle of its period.
- R7: A frame whose stop bit is low is discarded, and the holding register keeps its previous contents.
- R8: A read of the data word while a byte is held returns that byte zero-extended to 32 bits and empties the holding register.
- R9: A read of the data word with nothing held returns 0xFFFFFFFF.
- R10: A byte that arrives while an earlier one is still unread replaces it.
- R11: While the port is disabled, `line_tx` stays high, `line_rx` is ignored, and data writes complete without wait states and without sending anything.
- R12: Offsets that are not word-aligned, and word offsets above 0x8, read as zero and ignore writes. Reads never insert wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | A bus transfer is presented |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Transfer completes at the clock edge where it is high together with `bus_valid` |
| line_tx | output | 1 | Serial transmit line, idle high |
| line_rx | input | 1 | Serial receive line, asynchronous |

## Verification
The bound checker tests the following on every cycle:
- a wait state only ever comes from a data write that collides with a busy transmitter;
- reads never stall;
- an accepted data write drives the start bit on the next cycle;
- a disabled port keeps the line high and the receiver idle;
- a consuming read empties the holding register unless a byte lands at the same edge;
- an empty data read returns all ones.

Some properties need whole frames and are shown only by the bench's scenarios:
- the bit order and bit length on the line;
- the exact wait-state count of a stalled write;
- that frames with a bad stop bit are dropped;
- that a newer byte replaces an unread one;
- that the receiver ignores the line while disabled.

// File: rtl/mmio_uart_pkg.sv
`timescale 1ns/1ps
package mmio_uart_pkg;
  localparam int BUS_W  = 32;
  localparam int DIV_W  = 32;
  localparam int BYTE_W = 8;

  typedef logic [DIV_W-1:0] div_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    SEL_DIV,
    SEL_DATA,
    SEL_EN,
    SEL_NONE
  } reg_sel_e;

  // Clock cycles per serial bit; a zero divider behaves as one.
  function automatic div_t bit_cycles(input div_t div);
    return (div == '0) ? div_t'(1) : div;
  endfunction

  // Cycles from a detected falling edge to the start-bit check, at least one.
  function automatic div_t half_cycles(input div_t div);
    div_t h;
    h = bit_cycles(div) >> 1;
    return (h == '0) ? div_t'(1) : h;
  endfunction

  // Word returned by a data-register read.
  function automatic logic [BUS_W-1:0] rx_word(input logic held,
                                               input logic [BYTE_W-1:0] b);
    return held ? {{(BUS_W-BYTE_W){1'b0}}, b} : {BUS_W{1'b1}};
  endfunction
endpackage

// File: rtl/mmio_uart_tx.sv
`timescale 1ns/1ps
module mmio_uart_tx
  import mmio_uart_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  input  div_t              div,
  output logic              busy,
  output logic              line_tx
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int LEFT_W  = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  div_t               cnt;
  div_t               per;
  logic [LEFT_W-1:0]  left;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy  <= 1'b0;
      shreg <= '1;
      cnt   <= '0;
      per   <= div_t'(1);
      left  <= '0;
    end else if (start) begin
      shreg <= {1'b1, din, 1'b0};
      per   <= bit_cycles(div);
      cnt   <= bit_cycles(div) - div_t'(1);
      left  <= LEFT_W'(FRAME_W - 1);
      busy  <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) begin
        if (left == '0) begin
          busy  <= 1'b0;
          shreg <= '1;
        end else begin
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          left  <= left - LEFT_W'(1);
          cnt   <= per - div_t'(1);
        end
      end else begin
        cnt <= cnt - div_t'(1);
      end
    end
  end

  assign line_tx = (en && busy) ? shreg[0] : 1'b1;
endmodule

// File: rtl/mmio_uart_rx.sv
`timescale 1ns/1ps
module mmio_uart_rx
  import mmio_uart_pkg::*;
#(
  parameter int DATA_W      = BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              line_rx,
  input  div_t              div,
  output logic              done,
  output logic              frame_err,
  output logic              active,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int IDX_W = $clog2(DATA_W);

  logic              rx_s;
  logic              rx_prev;
  rx_state_e         st;
  div_t              cnt;
  div_t              per;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      logic [SYNC_STAGES-1:0] sy;
      always_ff @(posedge clk) begin
        if (rst) sy <= '1;
        else     sy <= {sy[SYNC_STAGES-2:0], line_rx};
      end
      assign rx_s = sy[SYNC_STAGES-1];
    end else begin : g_single
      logic sy;
      always_ff @(posedge clk) begin
        if (rst) sy <= 1'b1;
        else     sy <= line_rx;
      end
      assign rx_s = sy;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rx_prev <= 1'b1;
    else     rx_prev <= rx_s;
  end

  wire bit_end = (cnt == '0);
  wire fall    = rx_prev && !rx_s;

  assign done      = (st == RX_STOP) && bit_end && rx_s;
  assign frame_err = (st == RX_STOP) && bit_end && !rx_s;
  assign active    = (st != RX_IDLE);
  assign rx_byte   = shreg;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      per   <= div_t'(1);
      idx   <= '0;
      shreg <= '0;
    end else begin
      unique case (st)
        RX_IDLE: begin
          if (fall) begin
            st  <= RX_START;
            per <= bit_cycles(div);
            cnt <= half_cycles(div) - div_t'(1);
          end
        end
        RX_START: begin
          if (bit_end) begin
            if (!rx_s) begin
              st  <= RX_DATA;
              cnt <= per - div_t'(1);
              idx <= '0;
            end else begin
              st <= RX_IDLE;
            end
          end else begin
            cnt <= cnt - div_t'(1);
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            shreg <= {rx_s, shreg[DATA_W-1:1]};
            cnt   <= per - div_t'(1);
            if (idx == IDX_W'(DATA_W - 1)) st <= RX_STOP;
            else                           idx <= idx + IDX_W'(1);
          end else begin
            cnt <= cnt - div_t'(1);
          end
        end
        RX_STOP: begin
          if (bit_end) st <= RX_IDLE;
          else         cnt <= cnt - div_t'(1);
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmio_uart_regs.sv
`timescale 1ns/1ps
module mmio_uart_regs
  import mmio_uart_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_ready,
  input  logic              tx_busy,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              uart_en,
  output div_t              divider,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_data,
  output logic              hold_valid,
  output logic              rd_consume
);
  localparam int WIDX_W = ADDR_W - 2;

  reg_sel_e          sel;
  logic [7:0]        en_q;
  logic [DATA_W-1:0] hold_q;
  logic              stall;
  logic              fire;

  wire [WIDX_W-1:0] widx = bus_addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      if      (widx == WIDX_W'(0)) sel = SEL_DIV;
      else if (widx == WIDX_W'(1)) sel = SEL_DATA;
      else if (widx == WIDX_W'(2)) sel = SEL_EN;
    end
  end

  assign uart_en    = |en_q;
  assign stall      = bus_valid && bus_we && (sel == SEL_DATA) && uart_en && tx_busy;
  assign bus_ready  = bus_valid && !stall;
  assign fire       = bus_valid && bus_ready;
  assign tx_start   = fire && bus_we && (sel == SEL_DATA) && uart_en;
  assign tx_data    = bus_wdata[DATA_W-1:0];
  assign rd_consume = fire && !bus_we && (sel == SEL_DATA);

  always_comb begin
    unique case (sel)
      SEL_DIV:  bus_rdata = divider;
      SEL_DATA: bus_rdata = rx_word(hold_valid, hold_q);
      SEL_EN:   bus_rdata = {{(BUS_W-8){1'b0}}, en_q};
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divider <= div_t'(1);
      en_q    <= '0;
    end else if (fire && bus_we) begin
      if (sel == SEL_DIV) divider <= bus_wdata;
      if (sel == SEL_EN)  en_q    <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      hold_q     <= '0;
    end else if (rx_done) begin
      hold_valid <= 1'b1;
      hold_q     <= rx_byte;
    end else if (rd_consume) begin
      hold_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mmio_uart.sv
`timescale 1ns/1ps
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_ready,
  output logic              line_tx,
  input  logic              line_rx
);
  // Internal events, named for the bound checker.
  logic              uart_en;
  div_t              divider;
  logic              tx_start;
  logic [BYTE_W-1:0] tx_data;
  logic              tx_busy;
  logic              rx_done;
  logic              rx_frame_err;
  logic              rx_active;
  logic [BYTE_W-1:0] rx_byte;
  logic              hold_valid;
  logic              rd_consume;

  mmio_uart_regs #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .tx_busy    (tx_busy),
    .rx_done    (rx_done),
    .rx_byte    (rx_byte),
    .uart_en    (uart_en),
    .divider    (divider),
    .tx_start   (tx_start),
    .tx_data    (tx_data),
    .hold_valid (hold_valid),
    .rd_consume (rd_consume)
  );

  mmio_uart_tx #(.DATA_W(BYTE_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .en      (uart_en),
    .start   (tx_start),
    .din     (tx_data),
    .div     (divider),
    .busy    (tx_busy),
    .line_tx (line_tx)
  );

  mmio_uart_rx #(.DATA_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .en        (uart_en),
    .line_rx   (line_rx),
    .div       (divider),
    .done      (rx_done),
    .frame_err (rx_frame_err),
    .active    (rx_active),
    .rx_byte   (rx_byte)
  );
endmodule

// File: rtl/mmio_uart_chk.sv
`timescale 1ns/1ps
module mmio_uart_chk #(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              bus_ready,
  input logic              line_tx,
  input logic              uart_en,
  input logic              tx_start,
  input logic              tx_busy,
  input logic              rx_done,
  input logic              rx_active,
  input logic              hold_valid,
  input logic              rd_consume
);
  wire data_addr = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));

  // R5
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |-> bus_we && data_addr && tx_busy && uart_en);

  // R12
  read_nowait_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_we |-> bus_ready);

  // R4
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !line_tx && tx_busy);

  // R11
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !uart_en |-> line_tx);

  // R11
  rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !uart_en |=> !rx_active);

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> hold_valid);

  // R8
  consume_chk: assert property (@(posedge clk) disable iff (rst)
    rd_consume && !rx_done |=> !hold_valid);

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_we && data_addr && !hold_valid |-> bus_rdata == {BUS_W{1'b1}});
endmodule

bind mmio_uart mmio_uart_chk #(.ADDR_W(ADDR_W), .BUS_W(mmio_uart_pkg::BUS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_ready  (bus_ready),
  .line_tx    (line_tx),
  .uart_en    (uart_en),
  .tx_start   (tx_start),
  .tx_busy    (tx_busy),
  .rx_done    (rx_done),
  .rx_active  (rx_active),
  .hold_valid (hold_valid),
  .rd_consume (rd_consume)
);

// File: tb/mmio_uart_test.sv
`timescale 1ns/1ps
module mmio_uart_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        line_tx;
  logic        line_rx = 1'b1;

  int checks = 0;
  int fails  = 0;
  int cur_p  = 12;
  bit mon_on = 1'b0;
  int mon_cnt = 0;
  logic [7:0] mon_byte [0:255];
  logic       mon_stop [0:255];

  always #2.5 clk = ~clk;

  mmio_uart uut (
    .clk (clk), .rst (rst), .bus_valid (bus_valid), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .bus_ready (bus_ready), .line_tx (line_tx), .line_rx (line_rx)
  );

  function automatic logic [31:0] exp_read(bit held, logic [7:0] b);
    return held ? {24'h0, b} : 32'hFFFF_FFFF;
  endfunction

  function automatic int frame_len(int div);
    return ((div == 0) ? 1 : div) * 10;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic xfer(input bit we, input logic [7:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output int waits);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
    waits = 0;
    #1;
    while (!bus_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] wd, output int waits);
    logic [31:0] dummy;
    xfer(1'b1, a, wd, dummy, waits);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    int w;
    xfer(1'b0, a, 32'h0, v, w);
    check(w == 0, "R12 read wait states", w, 0);
  endtask

  task automatic send_rx(input logic [7:0] b, input bit stop_ok, input int p);
    @(negedge clk);
    line_rx = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      line_rx = b[i];
      repeat (p) @(negedge clk);
    end
    line_rx = stop_ok;
    repeat (p) @(negedge clk);
    line_rx = 1'b1;
    repeat (p + 4) @(negedge clk);
  endtask

  task automatic tx_byte(input logic [7:0] b, input string tag);
    int c0, w;
    c0 = mon_cnt;
    wr(8'h04, {24'hABCDEF, b}, w);
    check(w == 0, {tag, " idle write no wait"}, w, 0);
    check(line_tx == 1'b0, {tag, " start bit next cycle"}, line_tx, 0);
    repeat (frame_len(cur_p) + 4) @(posedge clk);
    #1;
    check(mon_cnt == c0 + 1, {tag, " frame count"}, mon_cnt, c0 + 1);
    check(mon_byte[c0 % 256] == b && mon_stop[c0 % 256] == 1'b1,
          {tag, " frame content"}, {mon_stop[c0 % 256], mon_byte[c0 % 256]}, {1'b1, b});
  endtask

  // Line decoder, independent of the design's counters.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && !line_tx) begin
        int p;
        logic [7:0] b;
        p = cur_p;
        repeat (p / 2) @(posedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (p) @(posedge clk);
          #1;
          b[i] = line_tx;
        end
        repeat (p) @(posedge clk);
        #1;
        mon_byte[mon_cnt % 256] = b;
        mon_stop[mon_cnt % 256] = line_tx;
        mon_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_up();
  end

  initial begin
    logic [31:0] v;
    int w, c0;
    bit held;
    logic [7:0] hb;
    void'($urandom(32'd1357));

    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    #1;
    check(line_tx == 1'b1, "R1 line idle high", line_tx, 1);
    rd(8'h00, v); check(v == 32'd1, "R1 divider reset", v, 1);
    rd(8'h08, v); check(v == 32'd0, "R1 enable reset", v, 0);
    rd(8'h04, v); check(v == exp_read(0, 8'h0), "R1 data empty", v, 32'hFFFF_FFFF);

    // R2 divider read/write
    wr(8'h00, 32'h0000_28B1, w);
    rd(8'h00, v); check(v == 32'h28B1, "R2 divider readback", v, 32'h28B1);
    wr(8'h00, 32'd12, w);
    cur_p = 12;

    // R11 disabled port
    wr(8'h04, 32'h5A, w);
    check(w == 0, "R11 disabled write no wait", w, 0);
    held = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!line_tx) held = 1'b0;
    end
    check(held, "R11 line stays high while disabled", held, 1);
    send_rx(8'h33, 1'b1, 12);
    rd(8'h04, v); check(v == 32'hFFFF_FFFF, "R11 receiver ignores line", v, 32'hFFFF_FFFF);

    // R3 enable field
    wr(8'h08, 32'hFFFF_FF01, w);
    rd(8'h08, v); check(v == 32'h01, "R3 enable low byte only", v, 32'h01);
    mon_on = 1'b1;

    // R4 single transmit
    tx_byte(8'hA5, "R4");
    tx_byte(8'h01, "R4 lsb");

    // R5 stalled back-to-back writes
    c0 = mon_cnt;
    wr(8'h04, 32'h3C, w);
    wr(8'h04, 32'hC3, w);
    check(w == frame_len(12), "R5 wait states until frame end", w, frame_len(12));
    repeat (frame_len(12) + 4) @(posedge clk);
    #1;
    check(mon_cnt == c0 + 2, "R5 two frames sent", mon_cnt, c0 + 2);
    check(mon_byte[c0 % 256] == 8'h3C && mon_byte[(c0 + 1) % 256] == 8'hC3,
          "R5 frame order", {mon_byte[c0 % 256], mon_byte[(c0 + 1) % 256]}, 16'h3CC3);

    // R6 / R8 / R9 receive and consume
    send_rx(8'h96, 1'b1, 12);
    rd(8'h04, v); check(v == exp_read(1, 8'h96), "R6 R8 received byte", v, 32'h96);
    rd(8'h04, v); check(v == exp_read(0, 8'h0), "R9 empty after consume", v, 32'hFFFF_FFFF);

    // R7 bad stop bit
    send_rx(8'h44, 1'b0, 12);
    rd(8'h04, v); check(v == 32'hFFFF_FFFF, "R7 bad frame dropped", v, 32'hFFFF_FFFF);
    send_rx(8'h21, 1'b1, 12);
    send_rx(8'h55, 1'b0, 12);
    rd(8'h04, v); check(v == 32'h21, "R7 held byte kept", v, 32'h21);

    // R10 overwrite
    send_rx(8'h11, 1'b1, 12);
    send_rx(8'h22, 1'b1, 12);
    rd(8'h04, v); check(v == 32'h22, "R10 newer byte wins", v, 32'h22);
    rd(8'h04, v); check(v == 32'hFFFF_FFFF, "R10 then empty", v, 32'hFFFF_FFFF);

    // R12 unmapped
    rd(8'h0C, v); check(v == 32'h0, "R12 unmapped reads zero", v, 0);
    rd(8'h06, v); check(v == 32'h0, "R12 misaligned reads zero", v, 0);
    wr(8'h0C, 32'hDEAD_BEEF, w);
    check(w == 0, "R12 unmapped write no wait", w, 0);
    wr(8'h01, 32'h0000_0077, w);
    rd(8'h00, v); check(v == 32'd12, "R12 divider untouched", v, 12);

    // Random mix
    held = 1'b0; hb = '0;
    for (int it = 0; it < 16; it++) begin
      int p;
      logic [7:0] b;
      p = 8 + int'($urandom % 17);
      b = 8'($urandom);
      wr(8'h00, p, w);
      cur_p = p;
      if ($urandom % 2 == 0) begin
        tx_byte(b, "R4 random");
      end else begin
        send_rx(b, 1'b1, p);
        held = 1'b1; hb = b;
        if ($urandom % 2 == 0) begin
          rd(8'h04, v);
          check(v == exp_read(held, hb), "R6 random receive", v, exp_read(held, hb));
          held = 1'b0;
        end
      end
    end
    rd(8'h04, v);
    check(v == exp_read(held, hb), "R8 random final read", v, exp_read(held, hb));

    // R2 divider of zero gives one-cycle bits
    mon_on = 1'b0;
    wr(8'h00, 32'd0, w);
    wr(8'h04, 32'h0F, w);
    wr(8'h04, 32'hF0, w);
    check(w == frame_len(0), "R2 zero divider frame length", w, frame_len(0));
    repeat (20) @(posedge clk);

    // R11 disable after activity
    wr(8'h08, 32'h0, w);
    #1;
    check(line_tx == 1'b1, "R11 line high after disable", line_tx, 1);
    wr(8'h04, 32'h99, w);
    check(w == 0, "R11 write completes disabled", w, 0);

    finish_up();
  end
endmodule